// File: doc/BRIEF.md
# Fractional-Threshold Pulse Timestamper

This block assigns a fine arrival time to each pulse in a stream of digitised detector samples, taken one per clock. A free-running coarse counter advances with the sampling clock. When a trigger strobe marks the start of a pulse, the block averages the samples seen just before the trigger to estimate the pulse's floor level. It then captures a window of samples from the trigger on, and waits for the pulse amplitude that an upstream energy stage reports.

Once it has the amplitude, the block forms a threshold equal to a programmable fraction of that amplitude. It walks through the captured window, with the floor level subtracted from each sample, to find the first pair of neighbouring samples that straddle the threshold. A short sequential division then places the crossing between those two samples by straight-line interpolation. The result is a coarse count plus five fractional bits. Pulses whose threshold crossing cannot be bracketed by two samples are reported as rejected and get no timestamp.

Top module: `crossStamp`

## Requirements
- R1: The coarse counter resets to 0 and increases by 1 on every clock. A valid result carries in `stampCoarse` the counter value of the clock on which the lower of the two bracketing samples was presented, modulo 2^16.
- R2: The floor level is the sum of the 8 samples presented on the 8 clocks just before the trigger clock, shifted right by 3 (rounded down). It is subtracted from every captured sample before any comparison.
- R3: A trigger accepted while idle captures the sample presented on the trigger clock as index 0, plus the samples on the following 15 clocks as indices 1 to 15.
- R4: The threshold is floor(amplitude × k / 64). Here k is `fracCode`, sampled on the trigger clock and held within the range 3 to 32 (about 5% to 50%): codes 1 and 2 become 3, and codes above 32 become 32.
- R5: A `fracCode` of 0 selects k = 13, which is about 20% of the amplitude.
- R6: The crossing index i is the first index, 1 or higher, whose corrected sample is at or above the threshold. The corrected sample at index i−1 is below the threshold.
- R7: The fraction is floor(32 × (thr − a) / (b − a)), where a and b are the corrected samples at i−1 and i. It is limited to 31, so that a crossing exactly on sample b gives 31.
- R8: If the corrected sample at index 0 is already at or above the threshold, or if no captured sample reaches it, `stampBad` pulses for one cycle and `stampValid` stays low.
- R9: The amplitude strobe counts from the trigger clock onwards. The search looks at index 0 on clock P. P is the clock after index 15 is captured, or the clock after the amplitude strobe, whichever is later. Index i is examined on clock P+i. A valid result is registered on clock P+i+6. A rejection is registered on clock P+1 for a crossing at index 0, and on clock P+16 when nothing reaches the threshold.
- R10: A trigger strobe that arrives while an event is in progress is ignored. An amplitude strobe that arrives while idle is ignored.
- R11: `stampValid` and `stampBad` are low after reset, last exactly one cycle each, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 12 | Unsigned sample, one per clock |
| trigIn | input | 1 | Pulse-start strobe |
| peakValid | input | 1 | Amplitude strobe from the energy stage |
| peakIn | input | 12 | Floor-corrected pulse amplitude |
| fracCode | input | 6 | Threshold fraction in 1/64 units, 0 = default |
| stampValid | output | 1 | One-cycle strobe: timestamp ready |
| stampBad | output | 1 | One-cycle strobe: event rejected |
| stampCoarse | output | 16 | Coarse count of the lower bracketing sample |
| stampFrac | output | 5 | Fractional position in 1/32 of a sample period |

## Verification
The bench drives whole pulses and compares both result strobes against a behavioural model on every clock, so a latency that is off by one clock shows up as a mismatch. One pulse puts the threshold exactly on a sample: a divider that is not held at 31 would overflow to 0 there. Another pulse starts above the threshold: a search that accepts index 0 would emit a timestamp before the window opens. An amplitude strobe that arrives well after the capture checks that the search waits for it. Fraction codes of 0, 1 and 40 check the default and the clamps, since a missing clamp moves the crossing index. A stray trigger in the middle of an event and an amplitude strobe while idle would each corrupt the result if the block took them.

// File: rtl/crossStamp_pkg.sv
package crossStamp_pkg;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic startTrig;  // trigger accepted: latch floor, stamp, code, index 0
    logic store;      // write capture slot capAddr
    logic takePeak;   // latch amplitude
    logic scanStep;   // advance search, remember corrected sample
    logic loadDiv;    // crossing found: set up divider and coarse count
    logic divStep;    // one restoring-division step
    logic emitValid;  // register a timestamp
    logic emitBad;    // register a rejection
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_WAITPK, ST_SCAN, ST_DIV, ST_EMITV, ST_EMITB
  } state_t;

endpackage

// File: rtl/crossStampCtl.sv
module crossStampCtl
  import crossStamp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FB    = 5,
  localparam int IW   = $clog2(DEPTH),
  localparam int DCW  = $clog2(FB)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigIn,
  input  logic          peakValid,
  input  logic          hit,
  output ctrl_t         ctrl,
  output logic [IW-1:0] capAddr,
  output logic [IW-1:0] scanIdx
);

  state_t state, nextState;
  logic [IW-1:0]  capCnt;
  logic [IW-1:0]  idx;
  logic [DCW-1:0] divCnt;
  logic           peakSeen;

  assign capAddr = capCnt;
  assign scanIdx = idx;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (trigIn) begin
          ctrl.startTrig = 1'b1;
          ctrl.takePeak  = peakValid;
          nextState      = ST_CAP;
        end
      end
      ST_CAP: begin
        ctrl.store    = 1'b1;
        ctrl.takePeak = peakValid && !peakSeen;
        if (capCnt == IW'(DEPTH - 1))
          nextState = (peakSeen || peakValid) ? ST_SCAN : ST_WAITPK;
      end
      ST_WAITPK: begin
        ctrl.takePeak = peakValid && !peakSeen;
        if (peakValid) nextState = ST_SCAN;
      end
      ST_SCAN: begin
        ctrl.scanStep = 1'b1;
        if (hit) begin
          if (idx == '0) nextState = ST_EMITB;
          else begin
            ctrl.loadDiv = 1'b1;
            nextState    = ST_DIV;
          end
        end else if (idx == IW'(DEPTH - 1)) begin
          nextState = ST_EMITB;
        end
      end
      ST_DIV: begin
        ctrl.divStep = 1'b1;
        if (divCnt == DCW'(FB - 1)) nextState = ST_EMITV;
      end
      ST_EMITV: begin
        ctrl.emitValid = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_EMITB: begin
        ctrl.emitBad = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      capCnt   <= '0;
      idx      <= '0;
      divCnt   <= '0;
      peakSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (ctrl.startTrig) begin
        capCnt   <= IW'(1);
        idx      <= '0;
        divCnt   <= '0;
        peakSeen <= peakValid;
      end else begin
        if (state == ST_CAP) capCnt <= capCnt + IW'(1);
        if ((state == ST_CAP || state == ST_WAITPK) && peakValid) peakSeen <= 1'b1;
        if (ctrl.scanStep && !hit) idx <= idx + IW'(1);
        if (ctrl.divStep) divCnt <= divCnt + DCW'(1);
      end
    end
  end

  // search never starts without an amplitude in hand
  assert_scan_has_peak_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> peakSeen);

  // a busy sequencer never restarts capture on a trigger
  assert_busy_trig_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && trigIn) |=> (capCnt != IW'(1) || $past(state) == ST_CAP));

endmodule

// File: rtl/crossStampDp.sv
module crossStampDp
  import crossStamp_pkg::*;
#(
  parameter int SW         = 12,
  parameter int CW         = 16,
  parameter int FB         = 5,
  parameter int DEPTH      = 16,
  parameter int BASE_LOG2  = 3,
  parameter int CODEW      = 6,
  parameter int SCALE_LOG2 = 6,
  parameter int CODE_MIN   = 3,
  parameter int CODE_MAX   = 32,
  parameter int CODE_DEF   = 13,
  localparam int IW        = $clog2(DEPTH),
  localparam int NBASE     = 1 << BASE_LOG2,
  localparam int DW        = SW + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [IW-1:0] capAddr,
  input  logic [IW-1:0] scanIdx,
  input  logic [SW-1:0] sampleIn,
  input  logic [SW-1:0] peakIn,
  input  logic [CODEW-1:0] fracCode,
  output logic          hit,
  output logic          stampValid,
  output logic          stampBad,
  output logic [CW-1:0] stampCoarse,
  output logic [FB-1:0] stampFrac
);

  logic [CW-1:0]    coarseCnt;
  logic [SW-1:0]    hist [NBASE];
  logic [SW-1:0]    sampleBuf [DEPTH];
  logic [SW+BASE_LOG2-1:0] histSum;
  logic [SW-1:0]    baseReg;
  logic [CW-1:0]    stampReg;
  logic [CODEW-1:0] codeReg, codeEff;
  logic [SW-1:0]    peakReg;
  logic [SW-1:0]    thr;
  logic [SW+CODEW-1:0] prod;
  logic signed [SW+1:0] corrNow, prevCorr;
  logic signed [DW-1:0] numS, denS;
  logic [DW-1:0]    rem, den, remShift;
  logic [FB-1:0]    quo;
  logic [CW-1:0]    coarseReg;

  // free-running coarse time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coarseCnt <= '0;
    else       coarseCnt <= coarseCnt + CW'(1);
  end

  // pre-trigger history for the floor estimate
  genvar g;
  generate
    for (g = 0; g < NBASE; g++) begin : gHist
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       hist[g] <= '0;
        else if (g == 0) hist[g] <= sampleIn;
        else             hist[g] <= hist[g-1];
      end
    end
  endgenerate

  always_comb begin
    histSum = '0;
    for (int j = 0; j < NBASE; j++) histSum += (SW+BASE_LOG2)'(hist[j]);
  end

  always_comb begin
    if (fracCode == '0)                      codeEff = CODEW'(CODE_DEF);
    else if (fracCode < CODEW'(CODE_MIN))    codeEff = CODEW'(CODE_MIN);
    else if (fracCode > CODEW'(CODE_MAX))    codeEff = CODEW'(CODE_MAX);
    else                                     codeEff = fracCode;
  end

  // capture window
  always_ff @(posedge clk) begin
    if (ctrl.startTrig)  sampleBuf[0]       <= sampleIn;
    else if (ctrl.store) sampleBuf[capAddr] <= sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      stampReg <= '0;
      codeReg  <= CODEW'(CODE_DEF);
      peakReg  <= '0;
    end else begin
      if (ctrl.startTrig) begin
        baseReg  <= SW'(histSum >> BASE_LOG2);
        stampReg <= coarseCnt;
        codeReg  <= codeEff;
      end
      if (ctrl.takePeak) peakReg <= peakIn;
    end
  end

  // threshold and search
  assign prod    = (SW+CODEW)'(peakReg) * (SW+CODEW)'(codeReg);
  assign thr     = SW'(prod >> SCALE_LOG2);
  assign corrNow = $signed({2'b00, sampleBuf[scanIdx]}) - $signed({2'b00, baseReg});
  assign hit     = corrNow >= $signed({2'b00, thr});

  assign numS = $signed({3'b000, thr}) - $signed({prevCorr[SW+1], prevCorr});
  assign denS = $signed({corrNow[SW+1], corrNow}) - $signed({prevCorr[SW+1], prevCorr});
  assign remShift = {rem[DW-2:0], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCorr  <= '0;
      rem       <= '0;
      den       <= '0;
      quo       <= '0;
      coarseReg <= '0;
    end else begin
      if (ctrl.scanStep) prevCorr <= corrNow;
      if (ctrl.loadDiv) begin
        rem       <= DW'(numS);
        den       <= DW'(denS);
        quo       <= '0;
        coarseReg <= stampReg + CW'(scanIdx) - CW'(1);
      end else if (ctrl.divStep) begin
        if (remShift >= den) begin
          rem <= remShift - den;
          quo <= {quo[FB-2:0], 1'b1};
        end else begin
          rem <= remShift;
          quo <= {quo[FB-2:0], 1'b0};
        end
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stampValid  <= 1'b0;
      stampBad    <= 1'b0;
      stampCoarse <= '0;
      stampFrac   <= '0;
    end else begin
      stampValid <= ctrl.emitValid;
      stampBad   <= ctrl.emitBad;
      if (ctrl.emitValid) begin
        stampCoarse <= coarseReg;
        stampFrac   <= quo;
      end
    end
  end

  assert_thr_half_R4: assert property (@(posedge clk) disable iff (!rstN)
    thr <= (peakReg >> 1));

  assert_coarse_in_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |-> (CW'(stampCoarse - stampReg) < CW'(DEPTH - 1)));

  assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |=> !stampValid);

  assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(stampValid && stampBad));

endmodule

// File: rtl/crossStamp.sv
module crossStamp
  import crossStamp_pkg::*;
#(
  parameter int SW        = 12,
  parameter int CW        = 16,
  parameter int FB        = 5,
  parameter int DEPTH     = 16,
  parameter int BASE_LOG2 = 3,
  parameter int CODEW     = 6,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SW-1:0]    sampleIn,
  input  logic             trigIn,
  input  logic             peakValid,
  input  logic [SW-1:0]    peakIn,
  input  logic [CODEW-1:0] fracCode,
  output logic             stampValid,
  output logic             stampBad,
  output logic [CW-1:0]    stampCoarse,
  output logic [FB-1:0]    stampFrac
);

  ctrl_t         ctrl;
  logic [IW-1:0] capAddr, scanIdx;
  logic          hit;

  crossStampCtl #(.DEPTH(DEPTH), .FB(FB)) u_ctl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .peakValid(peakValid), .hit(hit),
    .ctrl(ctrl), .capAddr(capAddr), .scanIdx(scanIdx)
  );

  crossStampDp #(
    .SW(SW), .CW(CW), .FB(FB), .DEPTH(DEPTH), .BASE_LOG2(BASE_LOG2), .CODEW(CODEW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .capAddr(capAddr), .scanIdx(scanIdx),
    .sampleIn(sampleIn), .peakIn(peakIn), .fracCode(fracCode), .hit(hit),
    .stampValid(stampValid), .stampBad(stampBad),
    .stampCoarse(stampCoarse), .stampFrac(stampFrac)
  );

endmodule

// File: tb/crossStamp_tb.sv
module crossStamp_tb;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        trigIn = 1'b0;
  logic        peakValid = 1'b0;
  logic [11:0] peakIn = '0;
  logic [5:0]  fracCode = '0;
  logic        stampValid, stampBad;
  logic [15:0] stampCoarse;
  logic [4:0]  stampFrac;

  int checks = 0;
  int fails  = 0;
  int edgeNo = 0;
  bit running = 1'b0;

  int    expEdge = -10;
  int    expKind = 0;  // 0 none, 1 valid, 2 rejected
  int    expCoarse = 0;
  int    expFrac = 0;
  string expTag = "";

  crossStamp u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .trigIn(trigIn),
    .peakValid(peakValid), .peakIn(peakIn), .fracCode(fracCode),
    .stampValid(stampValid), .stampBad(stampBad),
    .stampCoarse(stampCoarse), .stampFrac(stampFrac)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rstN) edgeNo <= edgeNo + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edgeNo - 1);
    end
  endtask

  // per-clock comparison against the model's expected event
  always @(negedge clk) begin
    if (running) begin
      bit wantV, wantB;
      wantV = (expKind == 1) && (expEdge == edgeNo - 1);
      wantB = (expKind == 2) && (expEdge == edgeNo - 1);
      check({expTag, " R9 R11 stampValid timing"}, int'(stampValid), int'(wantV));
      check({expTag, " R8 R11 stampBad timing"}, int'(stampBad), int'(wantB));
      if (wantV && stampValid) begin
        check({expTag, " R1 R6 coarse"}, int'(stampCoarse), expCoarse);
        check({expTag, " R7 fraction"}, int'(stampFrac), expFrac);
      end
    end
  end

  task automatic runCase(string tag, int baseVal, int lift, int slope, int amp, int r0,
                         int code, int pkDelay, int peakOvr, bit strays);
    int pre[8];
    int pulse[DEPTH];
    int corr[DEPTH];
    int sum, base, k, thr, peak, t0, p, hitIdx, num, dn, f;
    sum = 0;
    for (int j = 0; j < 8; j++) begin
      pre[j] = baseVal + (j % 4);
      sum += pre[j];
    end
    base = sum / 8;  // R2
    peak = 0;
    for (int i = 0; i < DEPTH; i++) begin
      int rise;
      rise = (i < r0) ? 0 : (i - r0) * slope;
      if (rise > amp) rise = amp;
      pulse[i] = baseVal + lift + rise;
      corr[i]  = pulse[i] - base;
      if (corr[i] > peak) peak = corr[i];
    end
    if (peakOvr >= 0) peak = peakOvr;
    // R4 / R5: code mapping
    if (code == 0) k = 13;
    else if (code < 3) k = 3;
    else if (code > 32) k = 32;
    else k = code;
    thr = (peak * k) / 64;

    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      sampleIn  = 12'(pre[j]);
      trigIn    = 1'b0;
      // R10: amplitude strobe while idle, deliberately misleading
      peakValid = strays && (j == 2);
      peakIn    = 12'(0);
    end
    @(negedge clk);
    t0        = edgeNo;
    sampleIn  = 12'(pulse[0]);
    trigIn    = 1'b1;
    fracCode  = 6'(code);
    peakValid = (pkDelay == 0);
    peakIn    = 12'(peak);

    // R9: search start
    p = (pkDelay <= DEPTH - 1) ? t0 + DEPTH : t0 + pkDelay + 1;
    hitIdx = -1;
    for (int i = 0; i < DEPTH; i++)
      if (hitIdx < 0 && corr[i] >= thr) hitIdx = i;
    expTag = tag;
    if (hitIdx == 0) begin
      expKind = 2; expEdge = p + 1;            // R8
    end else if (hitIdx < 0) begin
      expKind = 2; expEdge = p + DEPTH;        // R8
    end else begin
      num = thr - corr[hitIdx-1];
      dn  = corr[hitIdx] - corr[hitIdx-1];
      f   = (num * 32) / dn;
      if (f > 31) f = 31;                      // R7
      expKind   = 1;
      expEdge   = p + hitIdx + 6;
      expCoarse = (t0 + hitIdx - 1) % 65536;   // R1 R3 R6
      expFrac   = f;
    end

    for (int n = 1; edgeNo <= expEdge + 2; n++) begin
      @(negedge clk);
      trigIn    = strays && (n == 5);          // R10: trigger while busy
      sampleIn  = 12'((n < DEPTH) ? pulse[n] : baseVal);
      peakValid = (n == pkDelay);
      peakIn    = 12'(peak);
    end
    @(negedge clk);
    trigIn    = 1'b0;
    peakValid = 1'b0;
    expKind   = 0;
  endtask

  initial begin
    // reset state (R11, R1)
    repeat (3) @(negedge clk);
    check("R11 reset stampValid", int'(stampValid), 0);
    check("R11 reset stampBad", int'(stampBad), 0);
    check("R1 reset coarse output", int'(stampCoarse), 0);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;

    runCase("A default code R5", 100, 0, 300, 2000, 3, 0, 3, -1, 1'b0);
    runCase("B exact hit R7", 100, 0, 200, 2000, 2, 32, 2, 798, 1'b0);
    runCase("C low clamp R4 late peak R9", 200, 0, 150, 3000, 4, 1, 22, -1, 1'b0);
    runCase("D high clamp R4", 50, 0, 90, 1500, 1, 40, 15, -1, 1'b0);
    runCase("E above at index 0 R8", 100, 5, 100, 500, 0, 13, 1, 0, 1'b0);
    runCase("F never reached R8", 100, 0, 50, 1000, 2, 32, 4, 4000, 1'b0);
    runCase("G strays ignored R10", 300, 0, 120, 2500, 5, 20, 6, -1, 1'b1);
    runCase("H slow rise R6 R2 R3", 80, 0, 37, 900, 6, 7, 0, -1, 1'b0);

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule